// File: doc/BRIEF.md
# CAN Fault-Confinement State Monitor

This block keeps the two 8-bit error counters of a CAN node and works out its fault-confinement state from them. The bus engine sends it single-cycle events: a transmit error, a transmit success, a receive error and a receive success. It also sends one strobe for each kind of protocol error it finds. The block adds these events into the counters and derives the warning, error-passive and bus-off levels. It latches the protocol errors as sticky status bits and raises an interrupt flag each time the node enters one of the three fault levels.

Software sees the block through one write port and a set of read-only register outputs. It clears status and flag bits by writing 1 to them, programs the mask register, and resets both counters to leave bus-off. The single interrupt line goes high only when an unmasked flag is pending and the line-enable bit of the mask is set.

Top module: `can_fault_monitor`

## Requirements
- R1: Each `tx_err` cycle adds `TX_STEP` (default 8) to the transmit counter, capped at 255. Each `tx_ok` cycle subtracts 1, never going below 0. When both arrive in the same cycle, only the increment applies.
- R2: Each `rx_err` cycle adds 1 to the receive counter, capped at 255. Each `rx_ok` cycle subtracts 1, never going below 0. Saturating the receive counter never causes bus-off.
- R3: Status bit 16 (warning) is 1 exactly when the larger of the two counters is at or above 96.
- R4: Status bit 17 (error-passive) is 1 exactly when the larger of the two counters is at or above 128.
- R5: A transmit increment that would take the counter past 255 sets status bit 18 (bus-off) and leaves the counter at 255. While bus-off holds, all four counter events are ignored.
- R6: `perr_stb[i]` sets status bit 19+i. The order from i=0 upward is acknowledge, stuff, CRC, stuck-dominant, bit and form. The bits stay set until a write with `wr_sel`=0 carries a 1 in that position. A strobe wins over a clear in the same cycle. Such a write leaves bits 18..16 unchanged.
- R7: Flag bits 8, 9 and 10 are set one cycle after the node enters warning, error-passive or bus-off, in that order. They are not set again while the level persists. A write with `wr_sel`=1 clears the flag bits that carry a 1 in the data.
- R8: The mask register resets to 0x701 and is loaded from `wr_data` by a write with `wr_sel`=2. `irq0` is the OR of (flag bits 10..8 AND mask bits 10..8), ANDed with mask bit 0.
- R9: A write with `wr_sel`=3 sets both counters to 0 and ends bus-off in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_err | input | 1 | Transmit error event |
| tx_ok | input | 1 | Successful transmission event |
| rx_err | input | 1 | Receive error event |
| rx_ok | input | 1 | Successful reception event |
| perr_stb | input | 6 | Protocol error strobes (ack, stuff, CRC, stuck, bit, form) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 status, 1 flags, 2 mask, 3 counter reset |
| wr_data | input | 32 | Write data |
| tec_o | output | 8 | Transmit error counter |
| rec_o | output | 8 | Receive error counter |
| status_o | output | 32 | Error and status register |
| gif_o | output | 32 | Interrupt flag register |
| gim_o | output | 32 | Interrupt mask register |
| irq0 | output | 1 | Interrupt line 0 |

## Verification
The assertions assume one write per cycle on the write port. They also assume that after reset the counters move only through the event inputs or a counter-reset write. With those in place, bus-off always pins the transmit counter at its ceiling, and a rise of the passive level is always followed by its flag. The stimulus drives events as runs of whole clock cycles, changed only on the falling edge. It never overlaps a counter reset with counter events, so the freeze and reset checks see clean antecedents. Threshold crossings are reached by exact event counts, so each level change lands on a known cycle.

// File: rtl/can_fault_pkg.sv
package can_fault_pkg;
   typedef enum logic [1:0] {
      SEL_STATUS = 2'd0,
      SEL_FLAGS  = 2'd1,
      SEL_MASK   = 2'd2,
      SEL_CNTRST = 2'd3
   } wr_sel_e;

   localparam int ST_WARN    = 16;
   localparam int ST_PASS    = 17;
   localparam int ST_BOFF    = 18;
   localparam int ST_PERR_LO = 19;
   localparam int NUM_PERR   = 6;
   localparam int GF_LO      = 8;
   localparam int NUM_LVL    = 3;
   localparam int GM_LINE0   = 0;
endpackage

// File: rtl/fault_err_counter.sv
module fault_err_counter #(
   parameter int W              = 8,
   parameter int STEP           = 8,
   parameter bit BUS_OFF_ON_OVF = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         freeze,
   input  logic         up,
   input  logic         dn,
   output logic [W-1:0] cnt_o,
   output logic         ovf_o
);
   localparam logic [W:0] STEP_V = (W+1)'(STEP);
   localparam logic [W:0] MAX_V  = {1'b0, {W{1'b1}}};

   if (STEP < 1 || STEP > (1 << W) - 1) begin : g_bad_step
      $error("fault_err_counter: STEP out of range");
   end

   logic [W-1:0] cnt_q;
   logic [W:0]   sum;
   logic         past_top;

   assign sum      = {1'b0, cnt_q} + STEP_V;
   assign past_top = (sum > MAX_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (!freeze) begin
         if (up) begin
            cnt_q <= past_top ? MAX_V[W-1:0] : sum[W-1:0];
         end else if (dn && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   if (BUS_OFF_ON_OVF) begin : g_ovf
      logic ovf_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     ovf_q <= 1'b0;
         else if (clr)                   ovf_q <= 1'b0;
         else if (!freeze && up && past_top) ovf_q <= 1'b1;
      end
      assign ovf_o = ovf_q;
   end else begin : g_no_ovf
      assign ovf_o = 1'b0;
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/fault_w1c_bank.sv
module fault_w1c_bank #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] q_o
);
   if (N < 1) begin : g_bad_n
      $error("fault_w1c_bank: N must be positive");
   end

   logic [N-1:0] q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= (q & ~clr) | set;
   end

   assign q_o = q;
endmodule

// File: rtl/can_fault_monitor.sv
module can_fault_monitor
   import can_fault_pkg::*;
#(
   parameter int          CW          = 8,
   parameter int          TX_STEP     = 8,
   parameter int          WARN_LVL    = 96,
   parameter int          PASS_LVL    = 128,
   parameter logic [31:0] MASK_RESET  = 32'h0000_0701
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tx_err,
   input  logic          tx_ok,
   input  logic          rx_err,
   input  logic          rx_ok,
   input  logic [5:0]    perr_stb,
   input  logic          wr_en,
   input  logic [1:0]    wr_sel,
   input  logic [31:0]   wr_data,
   output logic [CW-1:0] tec_o,
   output logic [CW-1:0] rec_o,
   output logic [31:0]   status_o,
   output logic [31:0]   gif_o,
   output logic [31:0]   gim_o,
   output logic          irq0
);
   localparam int CMAX = (1 << CW) - 1;

   if (!(WARN_LVL > 0 && WARN_LVL < PASS_LVL && PASS_LVL <= CMAX)) begin : g_bad_lvl
      $error("can_fault_monitor: thresholds must satisfy 0 < WARN < PASS <= max count");
   end

   wr_sel_e sel;
   assign sel = wr_sel_e'(wr_sel);

   logic wr_status, wr_flags, wr_mask, cnt_rst;
   assign wr_status = wr_en && (sel == SEL_STATUS);
   assign wr_flags  = wr_en && (sel == SEL_FLAGS);
   assign wr_mask   = wr_en && (sel == SEL_MASK);
   assign cnt_rst   = wr_en && (sel == SEL_CNTRST);

   logic [CW-1:0] tec, rec;
   logic          bus_off, rec_ovf_unused;

   fault_err_counter #(.W(CW), .STEP(TX_STEP), .BUS_OFF_ON_OVF(1'b1)) u_tec (
      .clk(clk), .rst_n(rst_n), .clr(cnt_rst), .freeze(bus_off),
      .up(tx_err), .dn(tx_ok), .cnt_o(tec), .ovf_o(bus_off));

   fault_err_counter #(.W(CW), .STEP(1), .BUS_OFF_ON_OVF(1'b0)) u_rec (
      .clk(clk), .rst_n(rst_n), .clr(cnt_rst), .freeze(bus_off),
      .up(rx_err), .dn(rx_ok), .cnt_o(rec), .ovf_o(rec_ovf_unused));

   logic [CW-1:0] worst;
   logic          lvl_warn, lvl_pass;
   assign worst    = (tec > rec) ? tec : rec;
   assign lvl_warn = (int'(worst) >= WARN_LVL);
   assign lvl_pass = (int'(worst) >= PASS_LVL);

   logic [NUM_LVL-1:0] lvl_now, lvl_q, lvl_rise;
   assign lvl_now  = {bus_off, lvl_pass, lvl_warn};
   assign lvl_rise = lvl_now & ~lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= lvl_now;
   end

   logic [NUM_PERR-1:0] perr_q;
   fault_w1c_bank #(.N(NUM_PERR)) u_perr (
      .clk(clk), .rst_n(rst_n), .set(perr_stb),
      .clr(wr_status ? wr_data[ST_PERR_LO +: NUM_PERR] : '0),
      .q_o(perr_q));

   logic [NUM_LVL-1:0] flag_q;
   fault_w1c_bank #(.N(NUM_LVL)) u_flag (
      .clk(clk), .rst_n(rst_n), .set(lvl_rise),
      .clr(wr_flags ? wr_data[GF_LO +: NUM_LVL] : '0),
      .q_o(flag_q));

   logic [31:0] gim_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       gim_q <= MASK_RESET;
      else if (wr_mask) gim_q <= wr_data;
   end

   always_comb begin
      status_o = '0;
      status_o[ST_WARN] = lvl_warn;
      status_o[ST_PASS] = lvl_pass;
      status_o[ST_BOFF] = bus_off;
      status_o[ST_PERR_LO +: NUM_PERR] = perr_q;
      gif_o = '0;
      gif_o[GF_LO +: NUM_LVL] = flag_q;
   end

   assign gim_o = gim_q;
   assign irq0  = gim_q[GM_LINE0] & (|(flag_q & gim_q[GF_LO +: NUM_LVL]));
   assign tec_o = tec;
   assign rec_o = rec;
endmodule

// File: rtl/can_fault_monitor_chk.sv
module can_fault_monitor_chk #(
   parameter int CW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic [1:0]    wr_sel,
   input logic [CW-1:0] tec_o,
   input logic [CW-1:0] rec_o,
   input logic [31:0]   status_o,
   input logic [31:0]   gif_o,
   input logic [31:0]   gim_o,
   input logic          irq0
);
   // R5
   boff_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[18] |-> (&tec_o));

   // R5
   boff_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[18] && !(wr_en && wr_sel == 2'd3)) |=> ($stable(tec_o) && $stable(rec_o)));

   // R4
   pass_over_warn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[17] |-> status_o[16]);

   // R7
   pass_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_o[17]) |=> gif_o[9]);

   // R8
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq0 |-> (gim_o[0] && ((gif_o[10:8] & gim_o[10:8]) != 3'b000)));

   // R9
   cnt_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd3) |=> (tec_o == '0 && rec_o == '0 && !status_o[18]));
endmodule

bind can_fault_monitor can_fault_monitor_chk #(.CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
   .tec_o(tec_o), .rec_o(rec_o), .status_o(status_o), .gif_o(gif_o),
   .gim_o(gim_o), .irq0(irq0));

// File: tb/sim_can_fault_monitor.sv
module sim_can_fault_monitor;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tx_err = 0, tx_ok = 0, rx_err = 0, rx_ok = 0;
   logic [5:0]  perr_stb = '0;
   logic        wr_en = 0;
   logic [1:0]  wr_sel = '0;
   logic [31:0] wr_data = '0;
   logic [7:0]  tec_o, rec_o;
   logic [31:0] status_o, gif_o, gim_o;
   logic        irq0;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   can_fault_monitor u0 (
      .clk(clk), .rst_n(rst_n), .tx_err(tx_err), .tx_ok(tx_ok),
      .rx_err(rx_err), .rx_ok(rx_ok), .perr_stb(perr_stb),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .tec_o(tec_o), .rec_o(rec_o), .status_o(status_o),
      .gif_o(gif_o), .gim_o(gim_o), .irq0(irq0));

   // columns: tx_err, tx_ok, rx_err, rx_ok, expected tec, expected rec, expected status[18:16]
   localparam int NV = 5;
   localparam int VEC [NV][7] = '{
      '{11, 0,   0,  0, 88,   0, 0},
      '{ 1, 0,   0,  0, 96,   0, 1},
      '{ 0, 0, 130,  0, 96, 130, 3},
      '{ 0, 0,   0, 40, 96,  90, 1},
      '{ 0, 10,  0,  0, 86,  90, 0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic run(input int which, input int n);
      if (n > 0) begin
         @(negedge clk);
         case (which)
            0: tx_err = 1;
            1: tx_ok  = 1;
            2: rx_err = 1;
            default: rx_ok = 1;
         endcase
         repeat (n) @(negedge clk);
         tx_err = 0; tx_ok = 0; rx_err = 0; rx_ok = 0;
      end
   endtask

   task automatic wr(input logic [1:0] s, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1; wr_sel = s; wr_data = d;
      @(negedge clk);
      wr_en = 0; wr_data = '0;
   endtask

   task automatic settle();
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R8 reset mask", gim_o, 32'h701);
      chk("R3 reset status", status_o, 32'h0);
      chk("R7 reset flags", gif_o, 32'h0);
      chk("R1 reset tec", {24'h0, tec_o}, 32'h0);
      rst_n = 1'b1;

      for (int v = 0; v < NV; v++) begin
         run(0, VEC[v][0]);
         run(1, VEC[v][1]);
         run(2, VEC[v][2]);
         run(3, VEC[v][3]);
         settle();
         chk("R1 tec vector", {24'h0, tec_o}, VEC[v][4]);
         chk("R2 rec vector", {24'h0, rec_o}, VEC[v][5]);
         chk("R3 R4 level vector", {29'h0, status_o[18:16]}, VEC[v][6]);
      end

      chk("R7 flags after entries", gif_o, 32'h300);
      chk("R8 irq with flags", {31'h0, irq0}, 32'h1);
      wr(2'd1, 32'h700);
      chk("R7 w1c clear", gif_o, 32'h0);
      chk("R8 irq low", {31'h0, irq0}, 32'h0);

      run(2, 40); settle();
      chk("R7 re-entry flags", gif_o, 32'h300);
      wr(2'd1, 32'h300);
      run(2, 5); settle();
      chk("R7 no reassert while persisting", gif_o, 32'h0);

      run(3, 10); run(2, 5); settle();
      chk("R7 passive only", gif_o, 32'h200);
      wr(2'd2, 32'h200);
      chk("R8 line disabled", {31'h0, irq0}, 32'h0);
      wr(2'd2, 32'h501);
      chk("R8 bit masked", {31'h0, irq0}, 32'h0);
      wr(2'd2, 32'h701);
      chk("R8 mask readback", gim_o, 32'h701);
      chk("R8 irq enabled", {31'h0, irq0}, 32'h1);

      @(negedge clk); perr_stb = 6'b101001;
      @(negedge clk); perr_stb = '0;
      chk("R6 latched errors", status_o & 32'h01F8_0000, 32'h0148_0000);
      wr(2'd0, 32'h0108_0000);
      chk("R6 partial clear", status_o, 32'h0040_0000 | 32'h0003_0000);

      wr(2'd3, 32'h0);
      chk("R9 counters cleared", {16'h0, tec_o, rec_o}, 32'h0);
      chk("R9 levels cleared", {29'h0, status_o[18:16]}, 32'h0);
      run(1, 3); settle();
      chk("R1 floor at zero", {24'h0, tec_o}, 32'h0);

      wr(2'd1, 32'h700);
      run(0, 31); settle();
      chk("R5 before overflow", {23'h0, status_o[18], tec_o}, 32'd248);
      run(0, 1); settle();
      chk("R5 bus-off state", {23'h0, status_o[18], tec_o}, 32'h1FF);
      chk("R7 all three flags", gif_o, 32'h700);
      run(1, 5); run(2, 3); settle();
      chk("R5 frozen counters", {16'h0, tec_o, rec_o}, 32'hFF00);
      wr(2'd3, 32'h0);
      chk("R9 leaves bus-off", {23'h0, status_o[18], tec_o}, 32'h0);

      run(2, 300); settle();
      chk("R2 rec saturates", {24'h0, rec_o}, 32'hFF);
      chk("R2 no bus-off from rec", {29'h0, status_o[18:16]}, 32'h3);
      wr(2'd3, 32'h0);

      @(negedge clk); tx_err = 1; tx_ok = 1;
      @(negedge clk); tx_err = 0; tx_ok = 0;
      chk("R1 increment wins", {24'h0, tec_o}, 32'd8);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=complete");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule